// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block follows the power state of a DDR SDRAM by watching its clock-enable line and a decoded command code, one sample per rising clock edge. Every move between states is settled by three things taken together: the clock-enable level held from the previous edge, the level at the present edge, and the command registered at the present edge. The state in force is the one that held just before the edge. Two simple side inputs stand in for bank bookkeeping. One signals that a row was opened. The other signals that every bank is closed again.

It is placed next to a memory controller or on a bus monitor. It reports the current power state. It also keeps three sticky violation flags: one for combinations the device does not accept, one for commands other than NOP issued during the quiet interval that follows self-refresh exit, and one for reads issued before the DLL has had time to relock. A single clear pulse wipes all three flags.

The states and their named transitions are:
- IDLE (all banks idle). Moves to ACTIVE on an activate, to PD_PRE on *precharge power-down entry*, and to SELFREF on *self-refresh entry*.
- ACTIVE (one or more banks open). Moves to IDLE on *all closed* and to PD_ACT on *active power-down entry*.
- PD_PRE and PD_ACT. Each stays put on *maintain power-down* and returns to the state it came from on *power-down exit*.
- SELFREF. Stays put on *maintain self refresh* and moves to IDLE on *self-refresh exit*.

Top module: `cke_power_tracker`

## Requirements
- R1: A synchronous active-high reset puts the state at IDLE, clears all flags and both hold counters, and treats the previous clock-enable sample as high. The state codes are IDLE=0, ACTIVE=1, PD_PRE=2, PD_ACT=3 and SELFREF=4. The command codes are NOP/deselect=0, READ=1, WRITE=2, AUTO-REFRESH=3, and any other value counts as another command.
- R2: In SELFREF, clock enable low at both the previous and the current edge keeps the state at SELFREF, whatever the command.
- R3: In SELFREF, clock enable going low to high together with NOP moves the state to IDLE. The same edge loads both the exit-interval counter and the DLL counter.
- R4: In PD_PRE or PD_ACT, clock enable low on both edges keeps the state, whatever the command. Low to high together with NOP returns PD_PRE to IDLE and PD_ACT to ACTIVE.
- R5: In IDLE, clock enable going high to low with NOP enters PD_PRE. Going high to low with AUTO-REFRESH enters SELFREF.
- R6: In IDLE with clock enable high on both edges, the activate input moves the state to ACTIVE. In ACTIVE, clock enable high to low with NOP enters PD_ACT. Clock enable high on both edges with the all-closed input returns the state to IDLE.
- R7: For XSNR_CYCLES edges after the self-refresh exit edge, `exit_busy` is high. Any command other than NOP on one of those edges sets `viol_exit_cmd` after that edge.
- R8: For DLL_CYCLES edges after the self-refresh exit edge, `dll_busy` is high. A READ on one of those edges sets `viol_dll`. A READ after the interval does not.
- R9: Any other combination of state, clock-enable pair and command sets `viol_illegal` and leaves the state unchanged.
- R10: The flags are sticky until `flag_clr` is sampled high. A violation on the same edge as the clear wins, so that flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Observed clock-enable level |
| cmd | input | 3 | Decoded command code (see R1) |
| bank_act | input | 1 | A row was activated on this edge |
| banks_closed | input | 1 | All banks are precharged on this edge |
| flag_clr | input | 1 | Clear pulse for the sticky flags |
| pstate | output | 3 | Current power state code |
| exit_busy | output | 1 | Inside the NOP-only exit interval |
| dll_busy | output | 1 | Inside the DLL relock interval |
| viol_illegal | output | 1 | Sticky illegal-combination flag |
| viol_exit_cmd | output | 1 | Sticky non-NOP-during-exit flag |
| viol_dll | output | 1 | Sticky early-read flag |

## Verification
The bench builds the tracker with XSNR_CYCLES=8 and DLL_CYCLES=20 instead of the default 200 for each. This keeps both windows short enough to walk through edge by edge. Because the two lengths differ, there is a stretch where writes are accepted but reads are still blocked. That lets the bench test the last busy edge and the first free edge of each counter on its own. The short windows also let the bench enter and leave self refresh several times, to check clear-versus-set priority and the illegal sequences.

// File: rtl/cke_trk_pkg.sv
package cke_trk_pkg;

    typedef enum logic [2:0] {
        PS_IDLE    = 3'd0,
        PS_ACTIVE  = 3'd1,
        PS_PD_PRE  = 3'd2,
        PS_PD_ACT  = 3'd3,
        PS_SELFREF = 3'd4
    } pstate_e;

    localparam logic [2:0] CM_NOP     = 3'd0;
    localparam logic [2:0] CM_READ    = 3'd1;
    localparam logic [2:0] CM_WRITE   = 3'd2;
    localparam logic [2:0] CM_REFRESH = 3'd3;

    localparam int NUM_FLAGS = 3;
    localparam int FL_ILLEGAL = 0;
    localparam int FL_EXITCMD = 1;
    localparam int FL_DLL     = 2;

endpackage

// File: rtl/cke_hold_ctr.sv
module cke_hold_ctr #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy_o
);
    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] LOADV = W'(CYCLES);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOADV;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    always_comb busy_o = (cnt != '0);

    // R7, R8: a load opens the window on the following cycle
    p_ctr_load_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> busy_o);

    // R7, R8: the window shrinks by one per edge until it closes
    p_ctr_down_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !load) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/cke_sticky_flags.sv
module cke_sticky_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                flags_o[i] <= 1'b1;
            end else if (clr_i) begin
                flags_o[i] <= 1'b0;
            end
        end

        // R10: a raised flag survives any edge without a clear
        p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
            (flags_o[i] && !clr_i) |=> flags_o[i]);

        // R10: a set on the clearing edge still leaves the flag high
        p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
            (set_i[i] && clr_i) |=> flags_o[i]);
    end

endmodule

// File: rtl/cke_pstate_fsm.sv
module cke_pstate_fsm
    import cke_trk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cke,
    input  logic [2:0] cmd,
    input  logic    bank_act,
    input  logic    banks_closed,
    output pstate_e state_o,
    output logic    illegal_o,
    output logic    sr_exit_o
);
    pstate_e state, nxt;
    logic    cke_q;
    logic    is_nop;
    logic    illegal;
    logic    sr_exit;

    // state register, with the held clock-enable sample
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_IDLE;
            cke_q <= 1'b1;
        end else begin
            state <= nxt;
            cke_q <= cke;
        end
    end

    // next state, decided by (cke_q, cke, cmd)
    always_comb begin
        is_nop  = (cmd == CM_NOP);
        nxt     = state;
        illegal = 1'b0;
        sr_exit = 1'b0;
        unique case (state)
            PS_SELFREF: begin
                if (cke_q) begin
                    illegal = 1'b1;
                end else if (cke) begin
                    if (is_nop) begin
                        nxt     = PS_IDLE;
                        sr_exit = 1'b1;
                    end else begin
                        illegal = 1'b1;
                    end
                end
            end
            PS_PD_PRE, PS_PD_ACT: begin
                if (cke_q) begin
                    illegal = 1'b1;
                end else if (cke) begin
                    if (is_nop) begin
                        nxt = (state == PS_PD_PRE) ? PS_IDLE : PS_ACTIVE;
                    end else begin
                        illegal = 1'b1;
                    end
                end
            end
            PS_IDLE: begin
                if (!cke_q) begin
                    illegal = 1'b1;
                end else if (!cke) begin
                    if (is_nop) begin
                        nxt = PS_PD_PRE;
                    end else if (cmd == CM_REFRESH) begin
                        nxt = PS_SELFREF;
                    end else begin
                        illegal = 1'b1;
                    end
                end else if (bank_act) begin
                    nxt = PS_ACTIVE;
                end
            end
            PS_ACTIVE: begin
                if (!cke_q) begin
                    illegal = 1'b1;
                end else if (!cke) begin
                    if (is_nop) begin
                        nxt = PS_PD_ACT;
                    end else begin
                        illegal = 1'b1;
                    end
                end else if (banks_closed) begin
                    nxt = PS_IDLE;
                end
            end
            default: begin
                nxt     = PS_IDLE;
                illegal = 1'b1;
            end
        endcase
    end

    // outputs
    always_comb begin
        state_o   = state;
        illegal_o = illegal;
        sr_exit_o = sr_exit;
    end

    // R2: maintain self refresh
    p_sr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SELFREF && !cke_q && !cke) |=> (state == PS_SELFREF));

    // R3: self-refresh exit
    p_sr_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SELFREF && !cke_q && cke && cmd == CM_NOP) |=> (state == PS_IDLE));

    // R4: maintain power-down
    p_pd_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ((state == PS_PD_PRE || state == PS_PD_ACT) && !cke_q && !cke) |=> $stable(state));

    // R5: self-refresh entry
    p_sr_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (state == PS_IDLE && cke_q && !cke && cmd == CM_REFRESH) |=> (state == PS_SELFREF));

    // R9: a rejected combination leaves the state alone
    p_illegal_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> $stable(state));

endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
    import cke_trk_pkg::*;
#(
    parameter int XSNR_CYCLES = 200,
    parameter int DLL_CYCLES  = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cke,
    input  logic [2:0] cmd,
    input  logic       bank_act,
    input  logic       banks_closed,
    input  logic       flag_clr,
    output logic [2:0] pstate,
    output logic       exit_busy,
    output logic       dll_busy,
    output logic       viol_illegal,
    output logic       viol_exit_cmd,
    output logic       viol_dll
);
    pstate_e              st;
    logic                 illegal;
    logic                 sr_exit;
    logic [NUM_FLAGS-1:0] viol_set;
    logic [NUM_FLAGS-1:0] viol_q;

    cke_pstate_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cke          (cke),
        .cmd          (cmd),
        .bank_act     (bank_act),
        .banks_closed (banks_closed),
        .state_o      (st),
        .illegal_o    (illegal),
        .sr_exit_o    (sr_exit)
    );

    cke_hold_ctr #(.CYCLES(XSNR_CYCLES)) u_xsnr_ctr (
        .clk    (clk),
        .rst    (rst),
        .load   (sr_exit),
        .busy_o (exit_busy)
    );

    cke_hold_ctr #(.CYCLES(DLL_CYCLES)) u_dll_ctr (
        .clk    (clk),
        .rst    (rst),
        .load   (sr_exit),
        .busy_o (dll_busy)
    );

    always_comb begin
        viol_set              = '0;
        viol_set[FL_ILLEGAL]  = illegal;
        viol_set[FL_EXITCMD]  = exit_busy && (cmd != CM_NOP);
        viol_set[FL_DLL]      = dll_busy && (cmd == CM_READ);
    end

    cke_sticky_flags #(.N(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (viol_set),
        .clr_i   (flag_clr),
        .flags_o (viol_q)
    );

    always_comb begin
        pstate        = st;
        viol_illegal  = viol_q[FL_ILLEGAL];
        viol_exit_cmd = viol_q[FL_EXITCMD];
        viol_dll      = viol_q[FL_DLL];
    end

    // R1: reset state at the ports
    p_rst_idle_r1: assert property (@(posedge clk)
        rst |=> (pstate == 3'd0 && !viol_illegal && !viol_exit_cmd && !viol_dll
                 && !exit_busy && !dll_busy));

    // R7: a non-NOP command inside the exit interval is recorded
    p_exit_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        (exit_busy && cmd != CM_NOP) |=> viol_exit_cmd);

    // R8: an early read is recorded
    p_dll_read_r8: assert property (@(posedge clk) disable iff (rst)
        (dll_busy && cmd == CM_READ) |=> viol_dll);

    // R3: the exit edge opens both windows
    p_exit_opens_r3: assert property (@(posedge clk) disable iff (rst)
        (pstate == 3'd4 && sr_exit) |=> (exit_busy && dll_busy && pstate == 3'd0));

endmodule

// File: tb/test_cke_power_tracker.sv
module test_cke_power_tracker;

    localparam int XS  = 8;
    localparam int DL  = 20;
    localparam int TCK = 20;

    localparam logic [2:0] NOP = 3'd0, RD = 3'd1, WR = 3'd2, REF = 3'd3;
    localparam logic [2:0] S_IDLE = 3'd0, S_ACT = 3'd1, S_PDP = 3'd2,
                           S_PDA = 3'd3, S_SR = 3'd4;

    logic       clk = 1'b0;
    logic       rst;
    logic       cke;
    logic [2:0] cmd;
    logic       bank_act, banks_closed, flag_clr;
    logic [2:0] pstate;
    logic       exit_busy, dll_busy, viol_illegal, viol_exit_cmd, viol_dll;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(TCK/2) clk = ~clk;

    cke_power_tracker #(.XSNR_CYCLES(XS), .DLL_CYCLES(DL)) i_cke_power_tracker (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .bank_act(bank_act),
        .banks_closed(banks_closed), .flag_clr(flag_clr), .pstate(pstate),
        .exit_busy(exit_busy), .dll_busy(dll_busy), .viol_illegal(viol_illegal),
        .viol_exit_cmd(viol_exit_cmd), .viol_dll(viol_dll)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive on the falling edge, let one rising edge pass, sample after it
    task automatic step(input logic k, input logic [2:0] c,
                        input logic a = 1'b0, input logic z = 1'b0,
                        input logic cl = 1'b0);
        @(negedge clk);
        cke = k; cmd = c; bank_act = a; banks_closed = z; flag_clr = cl;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; cke = 1'b0; cmd = NOP; bank_act = 0; banks_closed = 0; flag_clr = 0;
        @(posedge clk); #2;
        check("R1 state", pstate, S_IDLE);
        check("R1 flags", {viol_illegal, viol_exit_cmd, viol_dll}, 0);
        check("R1 busy", {exit_busy, dll_busy}, 0);
        @(negedge clk); rst = 1'b0;
        // previous sample taken as high: a low now is an entry, not illegal
        @(posedge clk); #2;
        check("R1 prev-high entry", pstate, S_PDP);
        check("R1 no illegal", viol_illegal, 0);
    endtask

    task automatic t_pdn_pre;
        step(1'b0, RD);
        check("R4 hold pd_pre", pstate, S_PDP);
        step(1'b1, NOP);
        check("R4 exit to idle", pstate, S_IDLE);
        check("R4 no flags", {viol_illegal, viol_exit_cmd, viol_dll}, 0);
    endtask

    task automatic t_active;
        step(1'b1, NOP, 1'b1);
        check("R6 activate", pstate, S_ACT);
        step(1'b0, NOP);
        check("R6 active pd entry", pstate, S_PDA);
        step(1'b0, WR);
        check("R4 hold pd_act", pstate, S_PDA);
        step(1'b1, NOP);
        check("R4 exit to active", pstate, S_ACT);
        step(1'b1, NOP, 1'b0, 1'b1);
        check("R6 all closed", pstate, S_IDLE);
        check("R6 no flags", {viol_illegal, viol_exit_cmd, viol_dll}, 0);
    endtask

    task automatic t_selfref_dll;
        step(1'b0, REF);
        check("R5 sr entry", pstate, S_SR);
        for (int i = 0; i < 3; i++) step(1'b0, WR);
        check("R2 sr hold", pstate, S_SR);
        check("R2 no illegal", viol_illegal, 0);
        step(1'b1, NOP);
        check("R3 sr exit", pstate, S_IDLE);
        check("R3 windows open", {exit_busy, dll_busy}, 3);
        for (int i = 0; i < XS - 1; i++) step(1'b1, NOP);
        check("R7 last busy edge", exit_busy, 1);
        step(1'b1, NOP);
        check("R7 window closed", exit_busy, 0);
        check("R8 dll still busy", dll_busy, 1);
        step(1'b1, RD);
        check("R8 early read", viol_dll, 1);
        check("R7 read after window", viol_exit_cmd, 0);
        step(1'b1, NOP, 1'b0, 1'b0, 1'b1);
        check("R10 clear", viol_dll, 0);
        for (int i = 0; i < DL - XS - 3; i++) step(1'b1, NOP);
        check("R8 last dll edge", dll_busy, 1);
        step(1'b1, NOP);
        check("R8 dll closed", dll_busy, 0);
        step(1'b1, RD);
        check("R8 read allowed", viol_dll, 0);
    endtask

    task automatic t_exit_cmd;
        step(1'b0, REF);
        step(1'b1, NOP);
        check("R3 re-exit", pstate, S_IDLE);
        step(1'b1, WR);
        check("R7 write in window", viol_exit_cmd, 1);
        check("R8 write not read", viol_dll, 0);
        step(1'b1, WR, 1'b0, 1'b0, 1'b1);
        check("R10 set beats clear", viol_exit_cmd, 1);
        step(1'b1, NOP, 1'b0, 1'b0, 1'b1);
        check("R10 cleared", viol_exit_cmd, 0);
        for (int i = 0; i < XS - 4; i++) step(1'b1, NOP);
        check("R7 still busy", exit_busy, 1);
        step(1'b1, WR);
        check("R7 last-edge write", viol_exit_cmd, 1);
        step(1'b1, NOP, 1'b0, 1'b0, 1'b1);
        check("R7 window over", exit_busy, 0);
        step(1'b1, WR);
        check("R7 write after window", viol_exit_cmd, 0);
        for (int i = 0; i < 4 * DL && dll_busy; i++) step(1'b1, NOP);
        check("R8 dll drained", dll_busy, 0);
    endtask

    task automatic t_illegal;
        step(1'b0, WR);
        check("R9 idle hi-lo write", viol_illegal, 1);
        check("R9 state kept", pstate, S_IDLE);
        step(1'b1, NOP);
        check("R10 sticky", viol_illegal, 1);
        step(1'b1, NOP, 1'b0, 1'b0, 1'b1);
        check("R10 clear illegal", viol_illegal, 0);
        step(1'b0, REF);
        step(1'b1, RD);
        check("R9 sr lo-hi read", viol_illegal, 1);
        check("R9 sr kept", pstate, S_SR);
        step(1'b0, NOP, 1'b0, 1'b0, 1'b1);
        step(1'b1, NOP, 1'b0, 1'b0, 1'b1);
        check("R3 exit after illegal", pstate, S_IDLE);
        check("R10 cleared again", viol_illegal, 0);
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_pdn_pre();
        t_active();
        t_selfref_dll();
        t_exit_cmd();
        t_illegal();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule